// File: doc/BRIEF.md
# Funnel Shifter Unit

This block is a purely combinational N-bit shifter. One operand, a shift amount, a direction bit and a two-bit kind code go in; the shifted result comes out in the same cycle. Six operations are provided: logical, arithmetic and rotate, each to the left or to the right. The amount is always below N.

All six operations share one datapath. A word of 2N-1 bits is assembled from the operand and a fill pattern chosen by kind and direction. An N-bit window is then taken from that word at an offset. For right shifts the offset is the amount itself. For left shifts it is N-1-k, which is the bitwise inverse of the amount, so no adder is needed. The window is selected by log2(N) cascaded 2:1 multiplexer stages. Each stage is steered directly by one offset bit, so the amount is never decoded.

The block has no clock, no reset and no states. The result follows the inputs after the logic settles, so an instance sits between registers owned by the surrounding pipeline.

Top module: `shf_funnel_unit`

## Requirements
- R1: With an amount of 0, the result equals the operand for every kind code and both directions.
- R2: Kind code 2'b00 with direction 0 (right) shifts right and fills vacated upper bits with zeros.
- R3: Kind code 2'b01 with direction 0 (right) shifts right and fills vacated upper bits with copies of operand bit N-1.
- R4: Kind code 2'b00 with direction 1 (left) shifts left and fills vacated lower bits with zeros.
- R5: Kind code 2'b01 with direction 1 (left) gives the same result as R4.
- R6: Kind code 2'b10 with direction 0 rotates right: bits leaving bit 0 re-enter at bit N-1 (for N=4, 1011 by 1 gives 1101).
- R7: Kind code 2'b10 with direction 1 rotates left: bits leaving bit N-1 re-enter at bit 0 (for N=4, 1011 by 1 gives 0111).
- R8: Kind code 2'b11 behaves exactly as kind code 2'b00 in both directions.
- R9: The result depends only on the present inputs, with no storage: the output reflects each new input set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | WIDTH | Operand to be shifted |
| amt_i | input | $clog2(WIDTH) | Shift amount, 0 to WIDTH-1 |
| left_i | input | 1 | Direction: 1 left, 0 right |
| kind_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 treated as logical |
| res_o | output | WIDTH | Shifted result |

## Verification
The identity of a zero amount and the left-shift offset inversion act together: a left shift by 0 takes the window at the highest offset, N-1, and a fault there shows up only for left operations with k equal to 0. Likewise, the fill pattern and the window stages interact at the largest amount, where the result consists almost entirely of fill bits. The bench sweeps every amount, direction and kind code over operands with set sign bits, cleared sign bits and alternating bits. Each result is judged against a model built from the language's shift operators. Directed vectors at amounts 0 and N-1 isolate the two overlaps.

// File: rtl/shf_pkg.sv
package shf_pkg;
    typedef enum logic [1:0] {
        KIND_LOGIC  = 2'b00,
        KIND_ARITH  = 2'b01,
        KIND_ROTATE = 2'b10,
        KIND_SPARE  = 2'b11
    } shf_kind_e;
endpackage

// File: rtl/shf_word_build.sv
module shf_word_build
    import shf_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]   opnd,
    input  logic               left,
    input  shf_kind_e          kind,
    output logic [2*WIDTH-2:0] word
);
    localparam int FILL_W = WIDTH - 1;

    logic [FILL_W-1:0] fill_r;
    logic [FILL_W-1:0] fill_l;

    // Fill above the operand, used for right shifts.
    always_comb begin
        unique case (kind)
            KIND_ARITH:  fill_r = {FILL_W{opnd[WIDTH-1]}};
            KIND_ROTATE: fill_r = opnd[WIDTH-2:0];
            default:     fill_r = '0;   // logical and the spare code (R8)
        endcase
    end

    // Fill below the operand, used for left shifts (arithmetic equals logical, R5).
    always_comb begin
        unique case (kind)
            KIND_ROTATE: fill_l = opnd[WIDTH-1:1];
            default:     fill_l = '0;
        endcase
    end

    assign word = left ? {opnd, fill_l} : {fill_r, opnd};
endmodule

// File: rtl/shf_offset_sel.sv
module shf_offset_sel #(
    parameter int WIDTH = 8,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  logic [SH_W-1:0] amt,
    input  logic            left,
    output logic [SH_W-1:0] offset
);
    // Left: offset = WIDTH-1-amt, which for a power-of-two WIDTH is ~amt.
    assign offset = left ? ~amt : amt;
endmodule

// File: rtl/shf_window_mux.sv
module shf_window_mux #(
    parameter int WIDTH = 8,
    localparam int SH_W   = $clog2(WIDTH),
    localparam int WIDE_W = 2 * WIDTH - 1
) (
    input  logic [WIDE_W-1:0] word,
    input  logic [SH_W-1:0]   offset,
    output logic [WIDTH-1:0]  win
);
    // Most significant offset bit first; each stage drops the bits it no longer needs.
    for (genvar j = 0; j < SH_W; j++) begin : g_stage
        localparam int B  = SH_W - 1 - j;
        localparam int IW = WIDTH + (1 << (B + 1)) - 1;
        localparam int OW = WIDTH + (1 << B) - 1;
        logic [IW-1:0] vin;
        logic [OW-1:0] vout;
        if (j == 0) begin : g_first
            assign vin = word;
        end else begin : g_next
            assign vin = g_stage[j-1].vout;
        end
        assign vout = offset[B] ? vin[(1 << B) +: OW] : vin[OW-1:0];
    end

    assign win = g_stage[SH_W-1].vout;
endmodule

// File: rtl/shf_funnel_unit.sv
module shf_funnel_unit
    import shf_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int SH_W   = $clog2(WIDTH),
    localparam int WIDE_W = 2 * WIDTH - 1
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [SH_W-1:0]  amt_i,
    input  logic             left_i,
    input  logic [1:0]       kind_i,
    output logic [WIDTH-1:0] res_o
);
    shf_kind_e         kind;
    logic [WIDE_W-1:0] word;
    logic [SH_W-1:0]   offset;

    assign kind = shf_kind_e'(kind_i);

    shf_word_build #(.WIDTH(WIDTH)) u_build (
        .opnd (opnd_i),
        .left (left_i),
        .kind (kind),
        .word (word)
    );

    shf_offset_sel #(.WIDTH(WIDTH)) u_offset (
        .amt    (amt_i),
        .left   (left_i),
        .offset (offset)
    );

    shf_window_mux #(.WIDTH(WIDTH)) u_window (
        .word   (word),
        .offset (offset),
        .win    (res_o)
    );

    // Checks relating the result to the inputs across the three sub-blocks.
    always_comb begin
        if (amt_i == '0)
            a_r1_zero_amount: assert (res_o == opnd_i);
        if (!left_i && kind == KIND_ARITH)
            a_r3_sign_kept: assert (res_o[WIDTH-1] == opnd_i[WIDTH-1]);
        if (left_i && kind != KIND_ROTATE && amt_i != '0)
            a_r4_zero_tail: assert (res_o[0] == 1'b0);
        if (kind == KIND_ROTATE)  // R6 and R7
            a_r6_rotate_weight: assert ($countones(res_o) == $countones(opnd_i));
    end
endmodule

// File: tb/shf_funnel_unit_bench.sv
module shf_funnel_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int SW = $clog2(N);

    typedef struct packed {
        logic [N-1:0]  a;
        logic [SW-1:0] k;
        logic          lft;
        logic [1:0]    kd;
        logic [N-1:0]  y;
        logic [3:0]    req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{8'hB5, 3'd3, 1'b0, 2'd0, 8'h16, 4'd2},  // R2
        '{8'hB5, 3'd3, 1'b0, 2'd1, 8'hF6, 4'd3},  // R3
        '{8'hB5, 3'd3, 1'b1, 2'd0, 8'hA8, 4'd4},  // R4
        '{8'hB5, 3'd3, 1'b1, 2'd1, 8'hA8, 4'd5},  // R5
        '{8'hB5, 3'd3, 1'b0, 2'd2, 8'hB6, 4'd6},  // R6
        '{8'hB5, 3'd3, 1'b1, 2'd2, 8'hAD, 4'd7},  // R7
        '{8'hB5, 3'd3, 1'b0, 2'd3, 8'h16, 4'd8},  // R8
        '{8'hB5, 3'd0, 1'b1, 2'd2, 8'hB5, 4'd1},  // R1
        '{8'h80, 3'd7, 1'b0, 2'd1, 8'hFF, 4'd3},  // R3
        '{8'h7F, 3'd7, 1'b0, 2'd1, 8'h00, 4'd3},  // R3
        '{8'h01, 3'd7, 1'b1, 2'd2, 8'h80, 4'd7},  // R7
        '{8'hFF, 3'd7, 1'b0, 2'd0, 8'h01, 4'd2}   // R2
    };

    localparam logic [N-1:0] PATS [6] = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hB5, 8'h6A};

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [N-1:0]  a    = '0;
    logic [SW-1:0] k    = '0;
    logic          lft  = 1'b0;
    logic [1:0]    kd   = 2'b00;
    logic [N-1:0]  y;

    logic [3:0] a4   = '0;
    logic [1:0] k4   = '0;
    logic       lft4 = 1'b0;
    logic [1:0] kd4  = 2'b10;
    logic [3:0] y4;

    int applied = 0;
    int fails   = 0;

    shf_funnel_unit #(.WIDTH(N)) u_shf_funnel_unit (
        .opnd_i (a), .amt_i (k), .left_i (lft), .kind_i (kd), .res_o (y)
    );

    shf_funnel_unit #(.WIDTH(4)) u_shf_funnel_unit_w4 (
        .opnd_i (a4), .amt_i (k4), .left_i (lft4), .kind_i (kd4), .res_o (y4)
    );

    function automatic logic [N-1:0] ref_model(logic [N-1:0] v, int sh, logic l, logic [1:0] c);
        case (c)
            2'b10:   return l ? ((v << sh) | (v >> (N - sh))) : ((v >> sh) | (v << (N - sh)));
            2'b01:   return l ? (v << sh) : N'($signed(v) >>> sh);
            default: return l ? (v << sh) : (v >> sh);
        endcase
    endfunction

    function automatic int req_of(int sh, logic l, logic [1:0] c);
        if (sh == 0)  return 1;
        if (c == 2'b10) return l ? 7 : 6;
        if (c == 2'b11) return 8;
        if (l)          return (c == 2'b01) ? 5 : 4;
        return (c == 2'b01) ? 3 : 2;
    endfunction

    task automatic check(input logic [N-1:0] got, input logic [N-1:0] exp, input int req, input string what);
        applied++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] va, input int vk, input logic vl, input logic [1:0] vc);
        @(posedge clk);
        a = va; k = SW'(vk); lft = vl; kd = vc;
        @(negedge clk);
    endtask

    initial begin
        // Idle inputs: all zero gives zero (R1).
        @(negedge clk);
        check(y, '0, 1, "idle inputs");

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].a, int'(VECS[i].k), VECS[i].lft, VECS[i].kd);
            check(y, VECS[i].y, int'(VECS[i].req), $sformatf("table entry %0d", i));
        end

        // Full sweep against the operator model (R1..R8); one new set per cycle (R9).
        for (int p = 0; p < 6; p++)
            for (int c = 0; c < 4; c++)
                for (int d = 0; d < 2; d++)
                    for (int s = 0; s < N; s++) begin
                        apply(PATS[p], s, d[0], c[1:0]);
                        check(y, ref_model(PATS[p], s, d[0], c[1:0]), req_of(s, d[0], c[1:0]),
                              $sformatf("sweep a=%h k=%0d dir=%0d kind=%0d", PATS[p], s, d, c));
                    end

        // R9: back-to-back changes seen in consecutive cycles.
        apply(8'hC3, 1, 1'b0, 2'b00);
        check(y, 8'h61, 9, "first of back-to-back");
        apply(8'hC3, 1, 1'b1, 2'b00);
        check(y, 8'h86, 9, "second of back-to-back");

        // Four-bit instance: 1011 rotated by one each way.
        @(posedge clk);
        a4 = 4'b1011; k4 = 2'd1; lft4 = 1'b0; kd4 = 2'b10;
        @(negedge clk);
        check({4'h0, y4}, 8'h0D, 6, "w4 rotate right 1011");  // R6
        @(posedge clk);
        lft4 = 1'b1;
        @(negedge clk);
        check({4'h0, y4}, 8'h07, 7, "w4 rotate left 1011");   // R7
        @(posedge clk);
        kd4 = 2'b01; lft4 = 1'b0;
        @(negedge clk);
        check({4'h0, y4}, 8'h0D, 3, "w4 arithmetic right 1011");  // R3

        $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL R9 watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end
endmodule